// File: doc/BRIEF.md
# Dual External Interrupt Request Flags

This block turns two asynchronous, active-low interrupt pins into two interrupt request lines for an interrupt controller. Each channel has its own trigger-mode bit. In edge mode a falling edge on the pin latches a pending flag. The flag holds until the controller acknowledges that channel, or until software writes it. In level mode the request simply tracks the pin while it is held low, and nothing is latched.

Both pins pass through a synchronizer chain before any decision is made. Software reaches the mode bits and the pending state through one small register: a write strobe with a data word, and a read word that is always valid. Each channel takes two bits of that word. Bit 2i holds the mode of channel i, and bit 2i+1 holds the request of channel i. The controller acknowledges channel i with a one-cycle pulse on the matching acknowledge bit.

Top module: `xint_flag_unit`

## Requirements
- R1: After reset the read word is all zero and both request lines are low, with both pins idle high.
- R2: A register write sets the mode of channel i from data bit 2i at the next clock edge. Mode 1 means falling edge and mode 0 means low level. The mode reads back on bit 2i.
- R3: In edge mode, a synchronized falling edge sets the channel's pending flag. A rising edge, or a pin that is already low, does not set it. A set flag holds until cleared, drives the channel's request line and reads back on bit 2i+1.
- R4: In level mode the request line equals the inverted synchronized pin and is never latched. Acknowledges and writes to bit 2i+1 have no effect, and bit 2i+1 reads the live request.
- R5: In edge mode, an acknowledge pulse for channel i clears only channel i's flag at the next edge.
- R6: A falling edge in the same cycle as an acknowledge leaves the flag set.
- R7: A falling edge in the same cycle as a register write of 0 to the flag leaves the flag set.
- R8: A pin change clocked in at edge n shows up at different edges depending on the mode. In level mode the request changes at edge n+2. In edge mode the flag appears at edge n+3.
- R9: In edge mode, a register write loads bit 2i+1 into the flag. When no falling edge is present, the write takes precedence over an acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPinN | input | NUM_CH | Asynchronous active-low interrupt pins |
| ackIn | input | NUM_CH | Per-channel acknowledge pulse from the interrupt controller |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 2*NUM_CH | Write data: mode at bit 2i, flag at bit 2i+1 |
| regRdData | output | 2*NUM_CH | Read data: mode at bit 2i, request at bit 2i+1 |
| irqReq | output | NUM_CH | Per-channel interrupt request to the controller |

## Verification
The results arrive at different times after a stimulus:
- Register writes and acknowledges show up one edge after the edge that samples them.
- A level-mode pin change reaches the request line two edges after it is clocked in.
- An edge-mode flag needs three edges, because of the two synchronizer stages and the edge-detect stage.

The driver records the edge count at the moment it changes an input. It then queues each expected value tagged with the exact edge at which it is due, and an expectation one edge earlier confirms that nothing appears early. The monitor compares each item shortly after its edge, and any item still queued at the end counts as a failure.

// File: rtl/xint_pkg.sv
`timescale 1ns/1ps
package xint_pkg;
  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic flagLoad;
    logic flagVal;
    logic modeLoad;
    logic modeVal;
  } flagCtl_t;
endpackage

// File: rtl/xint_ctrl.sv
`timescale 1ns/1ps
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0]   fallEdge,
  input  logic [NUM_CH-1:0]   modeQ,
  input  logic [NUM_CH-1:0]   ackIn,
  input  logic                regWrEn,
  input  logic [2*NUM_CH-1:0] regWrData,
  output flagCtl_t            ctl [NUM_CH]
);
  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : gCh
      always_comb begin
        ctl[i].modeLoad = regWrEn;
        ctl[i].modeVal  = regWrData[2*i];
        ctl[i].flagLoad = 1'b0;
        ctl[i].flagVal  = 1'b0;
        if (!modeQ[i]) begin
          // level mode: stored flag kept clear (R4)
          ctl[i].flagLoad = 1'b1;
          ctl[i].flagVal  = 1'b0;
        end else if (fallEdge[i]) begin
          // hardware set beats ack and software write (R6, R7)
          ctl[i].flagLoad = 1'b1;
          ctl[i].flagVal  = 1'b1;
        end else if (regWrEn) begin
          ctl[i].flagLoad = 1'b1;         // R9
          ctl[i].flagVal  = regWrData[2*i+1];
        end else if (ackIn[i]) begin
          ctl[i].flagLoad = 1'b1;         // R5
          ctl[i].flagVal  = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xint_datapath.sv
`timescale 1ns/1ps
module xint_datapath
  import xint_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   extPinN,
  input  flagCtl_t            ctl [NUM_CH],
  output logic [NUM_CH-1:0]   fallEdge,
  output logic [NUM_CH-1:0]   modeQ,
  output logic [NUM_CH-1:0]   irqReq,
  output logic [2*NUM_CH-1:0] regRdData
);
  localparam int LAST = SYNC_STAGES - 1;

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : gCh
      logic [SYNC_STAGES-1:0] syncChain;
      logic prevSample;
      logic flagQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncChain  <= '1;
          prevSample <= 1'b1;
        end else begin
          syncChain  <= {syncChain[SYNC_STAGES-2:0], extPinN[i]};
          prevSample <= syncChain[LAST];
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          modeQ[i] <= 1'b0;
          flagQ    <= 1'b0;
        end else begin
          if (ctl[i].modeLoad) modeQ[i] <= ctl[i].modeVal;
          if (ctl[i].flagLoad) flagQ    <= ctl[i].flagVal;
        end
      end

      assign fallEdge[i]        = prevSample & ~syncChain[LAST];
      assign irqReq[i]          = modeQ[i] ? flagQ : ~syncChain[LAST];
      assign regRdData[2*i]     = modeQ[i];
      assign regRdData[2*i+1]   = irqReq[i];
    end
  endgenerate
endmodule

// File: rtl/xint_flag_unit.sv
`timescale 1ns/1ps
module xint_flag_unit
  import xint_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   extPinN,
  input  logic [NUM_CH-1:0]   ackIn,
  input  logic                regWrEn,
  input  logic [2*NUM_CH-1:0] regWrData,
  output logic [2*NUM_CH-1:0] regRdData,
  output logic [NUM_CH-1:0]   irqReq
);
  flagCtl_t          chCtl [NUM_CH];
  logic [NUM_CH-1:0] fallEdge;
  logic [NUM_CH-1:0] modeQ;

  xint_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .fallEdge (fallEdge),
    .modeQ    (modeQ),
    .ackIn    (ackIn),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .ctl      (chCtl)
  );

  xint_datapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .extPinN  (extPinN),
    .ctl      (chCtl),
    .fallEdge (fallEdge),
    .modeQ    (modeQ),
    .irqReq   (irqReq),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/xint_flag_unit_chk.sv
`timescale 1ns/1ps
module xint_flag_unit_chk #(
  parameter int NUM_CH = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_CH-1:0]   ackIn,
  input logic                regWrEn,
  input logic [2*NUM_CH-1:0] regWrData,
  input logic [2*NUM_CH-1:0] regRdData,
  input logic [NUM_CH-1:0]   irqReq,
  input logic [NUM_CH-1:0]   fallEdge
);
  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : gCh
      logic edgeMode;
      assign edgeMode = regRdData[2*i];

      AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
        regWrEn |=> regRdData[2*i] == $past(regWrData[2*i])); // R2
      AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
        (edgeMode && fallEdge[i] && !regWrEn) |=> irqReq[i]); // R3
      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (edgeMode && irqReq[i] && !ackIn[i] && !regWrEn) |=> irqReq[i]); // R3
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
        (edgeMode && !irqReq[i] && !fallEdge[i] && !regWrEn) |=> !irqReq[i]); // R3
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
        (edgeMode && ackIn[i] && !fallEdge[i] && !regWrEn) |=> !irqReq[i]); // R5
      AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rstN)
        (edgeMode && ackIn[i] && fallEdge[i] && !regWrEn) |=> irqReq[i]); // R6
      AST_EDGE_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
        (edgeMode && fallEdge[i] && regWrEn && regWrData[2*i]) |=> irqReq[i]); // R7
      AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rstN)
        (edgeMode && regWrEn && regWrData[2*i] && regWrData[2*i+1]) |=> regRdData[2*i+1]); // R9
    end
  endgenerate
endmodule

bind xint_flag_unit xint_flag_unit_chk #(.NUM_CH(NUM_CH)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ackIn    (ackIn),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .irqReq   (irqReq),
  .fallEdge (fallEdge)
);

// File: tb/xint_flag_unit_test.sv
`timescale 1ns/1ps
module xint_flag_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] extPinN = 2'b11;
  logic [1:0] ackIn = 2'b00;
  logic       regWrEn = 1'b0;
  logic [3:0] regWrData = 4'h0;
  logic [3:0] regRdData;
  logic [1:0] irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  int edgeCnt = 0;

  typedef struct {
    int at;
    logic [1:0] irqE, irqM;
    logic [3:0] rdE, rdM;
    string tag;
  } expItem_t;
  expItem_t sb[$];

  always #2.5 clk = ~clk;

  xint_flag_unit uut (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .ackIn(ackIn),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq)
  );

  task automatic expectAt(input int d, input logic [1:0] ie, input logic [1:0] im,
                          input logic [3:0] re, input logic [3:0] rm, input string tag);
    expItem_t e;
    e.at = edgeCnt + d; e.irqE = ie; e.irqM = im; e.rdE = re; e.rdM = rm; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [3:0] d);
    regWrEn = 1'b1; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  // monitor: compares queued items due at this edge
  initial forever begin
    @(posedge clk);
    edgeCnt++;
    #1;
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].at == edgeCnt) begin
        testsRun++;
        if ((((irqReq ^ sb[k].irqE) & sb[k].irqM) != 0) ||
            (((regRdData ^ sb[k].rdE) & sb[k].rdM) != 0)) begin
          testsFailed++;
          $display("FAIL %s at edge %0d: irq=%b rd=%b expected irq=%b(mask %b) rd=%b(mask %b)",
                   sb[k].tag, edgeCnt, irqReq, regRdData, sb[k].irqE, sb[k].irqM,
                   sb[k].rdE, sb[k].rdM);
        end
        sb.delete(k);
      end
    end
  end

  initial begin
    #100000;
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (4) tick();
    rstN = 1'b1;
    expectAt(1, 2'b00, 2'b11, 4'b0000, 4'hF, "R1 reset state");
    expectAt(3, 2'b00, 2'b11, 4'b0000, 4'hF, "R1 idle after reset");
    repeat (3) tick();

    // R2: both channels to edge mode
    expectAt(1, 2'b00, 2'b11, 4'b0101, 4'hF, "R2 mode write");
    writeReg(4'b0101);
    repeat (2) tick();

    // R3/R8: edge on channel 0
    extPinN[0] = 1'b0;
    expectAt(2, 2'b00, 2'b01, 4'b0, 4'b0, "R8 edge not early");
    expectAt(3, 2'b01, 2'b11, 4'b0111, 4'hF, "R3 edge sets flag");
    repeat (6) tick();
    expectAt(1, 2'b01, 2'b01, 4'b0, 4'b0, "R3 flag latched");
    extPinN[0] = 1'b1;
    expectAt(4, 2'b01, 2'b01, 4'b0, 4'b0, "R3 rising edge no clear");
    repeat (5) tick();

    // R5: ack channel 0
    ackIn = 2'b01;
    expectAt(1, 2'b00, 2'b11, 4'b0101, 4'hF, "R5 ack clears");
    tick(); ackIn = 2'b00;
    repeat (3) tick();

    // channel 1 edge, independent ack
    extPinN[1] = 1'b0;
    expectAt(3, 2'b10, 2'b11, 4'b1101, 4'hF, "R3 channel 1 edge");
    repeat (4) tick();
    ackIn = 2'b01;
    expectAt(1, 2'b10, 2'b11, 4'b0, 4'b0, "R5 other ack ignored");
    tick(); ackIn = 2'b00; extPinN[1] = 1'b1;
    repeat (2) tick();
    ackIn = 2'b10;
    expectAt(1, 2'b00, 2'b11, 4'b0, 4'b0, "R5 ack channel 1");
    tick(); ackIn = 2'b00;
    repeat (3) tick();

    // R4: channel 1 level mode
    expectAt(1, 2'b00, 2'b11, 4'b0001, 4'hF, "R2 mode to level");
    writeReg(4'b0001);
    tick();
    extPinN[1] = 1'b0;
    expectAt(1, 2'b00, 2'b10, 4'b0, 4'b0, "R8 level not early");
    expectAt(2, 2'b10, 2'b10, 4'b1001, 4'hF, "R4 level request");
    repeat (4) tick();
    ackIn = 2'b10;
    expectAt(1, 2'b10, 2'b10, 4'b0, 4'b0, "R4 ack no effect");
    tick(); ackIn = 2'b00;
    tick();
    extPinN[1] = 1'b1;
    expectAt(1, 2'b10, 2'b10, 4'b0, 4'b0, "R8 level release delay");
    expectAt(2, 2'b00, 2'b10, 4'b0001, 4'hF, "R4 not latched");
    repeat (4) tick();
    expectAt(1, 2'b00, 2'b10, 4'b0001, 4'hF, "R4 flag write ignored");
    writeReg(4'b1001);
    tick();

    // R9: software set in edge mode
    expectAt(1, 2'b01, 2'b11, 4'b0011, 4'hF, "R9 write sets flag");
    writeReg(4'b0011);
    tick();

    // R6: edge in same cycle as ack
    extPinN[0] = 1'b0;
    tick(); tick();
    ackIn = 2'b01;
    expectAt(1, 2'b01, 2'b01, 4'b0, 4'b0, "R6 edge beats ack");
    expectAt(2, 2'b01, 2'b01, 4'b0, 4'b0, "R6 flag kept");
    tick(); ackIn = 2'b00;
    tick(); extPinN[0] = 1'b1;
    repeat (4) tick();

    // R7: edge in same cycle as software clear
    extPinN[0] = 1'b0;
    tick(); tick();
    regWrEn = 1'b1; regWrData = 4'b0001;
    expectAt(1, 2'b01, 2'b11, 4'b0011, 4'hF, "R7 edge beats write");
    tick(); regWrEn = 1'b0;
    tick(); extPinN[0] = 1'b1;
    repeat (4) tick();

    // R9: software clear, then write beats ack
    expectAt(1, 2'b00, 2'b11, 4'b0001, 4'hF, "R9 write clears flag");
    writeReg(4'b0001);
    regWrEn = 1'b1; regWrData = 4'b0011; ackIn = 2'b01;
    expectAt(1, 2'b01, 2'b11, 4'b0011, 4'hF, "R9 write over ack");
    tick(); regWrEn = 1'b0; ackIn = 2'b00;
    repeat (3) tick();

    // R3: pin already low when switched to edge mode
    extPinN[1] = 1'b0;
    repeat (4) tick();
    expectAt(1, 2'b01, 2'b11, 4'b0111, 4'hF, "R3 no edge on switch");
    expectAt(4, 2'b01, 2'b11, 4'b0111, 4'hF, "R3 steady low ignored");
    writeReg(4'b0111);
    repeat (6) tick();

    if (sb.size() != 0) begin
      testsRun += sb.size();
      testsFailed += sb.size();
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
    end
    finish();
  end
endmodule